// File: doc/BRIEF.md
# Half-Warp Memory Access Coalescer

The coalescer receives one memory request on behalf of sixteen threads. Each thread gives a 32-bit byte address of a 4-byte word, and a mask shows which threads are active. The block reduces the request to a short list of aligned memory transactions. Each transaction has a base address and a size of 32, 64 or 128 bytes. Transactions leave one per cycle over a valid/ready handshake. When the list is empty, a one-cycle completion pulse marks the end of the request and the block returns to idle.

Two rule sets can be chosen per request. The strict rule merges the request only when all sixteen words are contiguous and start on a 64-byte boundary; in every other case it falls back to one 32-byte transaction per active thread. The relaxed rule groups the active words by aligned 128-byte segment. It then shrinks each touched segment to the smallest aligned 32-, 64- or 128-byte piece that covers the words used in it. This gives one transaction per segment in ascending address order.

Top module: `halfwarp_coalescer`

## Requirements
- R1: `in_ready` is high only while the block is idle, and a request (addresses, mask, mode) is captured on the clock edge where `in_valid` and `in_ready` are both high.
- R2: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_addr` and `out_size` stay unchanged on the next cycle.
- R3: `out_size` encodes 0 = 32 bytes, 1 = 64 bytes, 2 = 128 bytes, and `out_addr` is always a multiple of the encoded size.
- R4: In strict mode (`in_mode` = 0), if all 16 threads are active, thread k's word index (address bits 31:2) equals thread 0's plus k, and thread 0's word index is a multiple of 16, exactly one 64-byte transaction is issued at thread 0's address with bits 1:0 cleared.
- R5: In strict mode, any other request issues one 32-byte transaction per active thread, in ascending thread index, at that thread's address with bits 4:0 cleared.
- R6: In relaxed mode (`in_mode` = 1), exactly one transaction is issued per distinct 128-byte segment (address bits 31:7) touched by an active thread, in strictly ascending address order.
- R7: In relaxed mode, the 32-byte quarters (address bits 6:5) used inside a segment decide its transaction. A single quarter gives 32 bytes at that quarter. Two quarters in the same 64-byte half give 64 bytes at that half. Anything else gives 128 bytes at the segment base.
- R8: Addresses of inactive threads have no effect on the output, and a request with an all-zero mask issues no transaction.
- R9: `done` is high for exactly one cycle, the cycle after the last transaction's handshake (or the cycle after acceptance for an empty request), and `in_ready` is high on the cycle after `done`.
- R10: Mode, mask and addresses are sampled at acceptance only; changing the inputs while transactions are pending does not alter them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Block idle, request can be taken |
| in_mode | input | 1 | 0 = strict rule, 1 = relaxed rule |
| in_mask | input | 16 | Active thread mask, bit k = thread k |
| in_addr | input | 512 | Thread byte addresses, thread k in bits 32k+31:32k |
| out_valid | output | 1 | Transaction offered |
| out_ready | input | 1 | Transaction taken by memory side |
| out_addr | output | 32 | Transaction base byte address |
| out_size | output | 2 | Transaction size code |
| done | output | 1 | One-cycle completion pulse |

## Verification
On every cycle the assertions enforce: stable output under backpressure, size alignment of each address, strictly rising addresses in relaxed mode, a shrinking pending set on each handshake, and the single-cycle completion pulse followed by readiness. Only the bench's scenarios can show that the number and sizes of transactions are right. These cover both rule sets, offsets 0 to 32 words from segment-aligned and half-segment-aligned bases, boundary-crossing patterns (including the two-32-byte case at offset 8), partial and empty masks, and inputs changed after acceptance.

// File: rtl/coal_pkg.sv
package coal_pkg;
  typedef enum logic [1:0] {
    SZ_32  = 2'd0,
    SZ_64  = 2'd1,
    SZ_128 = 2'd2
  } txnSize_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } ctrlState_e;

  typedef struct packed {
    logic load;
    logic advance;
  } coalStrobe_t;
endpackage

// File: rtl/coal_ctrl.sv
module coal_ctrl
  import coal_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        inValid,
  input  logic        outReady,
  input  logic        pendEmpty,
  output logic        inReady,
  output logic        outValid,
  output logic        done,
  output coalStrobe_t strobe
);
  ctrlState_e state, stateNext;

  assign inReady        = (state == ST_IDLE);
  assign outValid       = (state == ST_RUN) && !pendEmpty;
  assign done           = (state == ST_RUN) && pendEmpty;
  assign strobe.load    = inReady && inValid;
  assign strobe.advance = outValid && outReady;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (inValid) stateNext = ST_RUN;
      ST_RUN:  if (pendEmpty) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  done_then_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> inReady);

  // R2
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outReady) |=> outValid);
endmodule

// File: rtl/coal_datapath.sv
module coal_datapath
  import coal_pkg::*;
#(
  parameter int NUM_THREADS = 16,
  parameter int ADDR_W      = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  coalStrobe_t                   strobe,
  input  logic [NUM_THREADS*ADDR_W-1:0] inAddr,
  input  logic [NUM_THREADS-1:0]        inMask,
  input  logic                          inMode,
  output logic                          pendEmpty,
  output logic [ADDR_W-1:0]             txnAddr,
  output txnSize_e                      txnSize
);
  localparam int WORD_LSB  = 2;
  localparam int QTR_LSB   = 5;
  localparam int HALF_LSB  = 6;
  localparam int SEG_LSB   = 7;
  localparam int WORD_W    = ADDR_W - WORD_LSB;
  localparam int SEG_W     = ADDR_W - SEG_LSB;
  localparam int IDX_W     = $clog2(NUM_THREADS);
  localparam int ALIGN_LSB = $clog2(NUM_THREADS);

  logic [ADDR_W-1:0]      addrQ   [NUM_THREADS];
  logic [WORD_W-1:0]      wordIdx [NUM_THREADS];
  logic [SEG_W-1:0]       segIdx  [NUM_THREADS];
  logic [3:0]             qtrHot  [NUM_THREADS];
  logic [NUM_THREADS-1:0] wordInLine;
  logic [NUM_THREADS-1:0] pend;
  logic                   modeQ;

  // per-thread capture and address slicing
  for (genvar g = 0; g < NUM_THREADS; g++) begin : g_thread
    assign wordIdx[g]    = addrQ[g][ADDR_W-1:WORD_LSB];
    assign segIdx[g]     = addrQ[g][ADDR_W-1:SEG_LSB];
    assign qtrHot[g]     = 4'b0001 << addrQ[g][SEG_LSB-1:QTR_LSB];
    assign wordInLine[g] = (wordIdx[g] == wordIdx[0] + WORD_W'(g));

    always_ff @(posedge clk) begin
      if (strobe.load) addrQ[g] <= inAddr[g*ADDR_W +: ADDR_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend  <= '0;
      modeQ <= 1'b0;
    end else if (strobe.load) begin
      pend  <= inMask;
      modeQ <= inMode;
    end else if (strobe.advance) begin
      pend  <= pend & ~clrMask;
    end
  end

  assign pendEmpty = (pend == '0);

  // strict rule: whole-group merge test and lowest pending thread
  logic             strictSingle;
  logic [IDX_W-1:0] lowIdx;
  logic             lowFound;

  assign strictSingle = (&pend) && (&wordInLine) &&
                        (wordIdx[0][ALIGN_LSB-1:0] == '0);

  always_comb begin
    lowIdx   = '0;
    lowFound = 1'b0;
    for (int k = 0; k < NUM_THREADS; k++) begin
      if (pend[k] && !lowFound) begin
        lowIdx   = IDX_W'(k);
        lowFound = 1'b1;
      end
    end
  end

  // relaxed rule: lowest touched segment and its used quarters
  logic [SEG_W-1:0]       minSeg;
  logic [NUM_THREADS-1:0] segClr;
  logic [3:0]             qMask;

  always_comb begin
    minSeg = '1;
    for (int k = 0; k < NUM_THREADS; k++) begin
      if (pend[k] && segIdx[k] <= minSeg) minSeg = segIdx[k];
    end
  end

  always_comb begin
    qMask  = '0;
    segClr = '0;
    for (int k = 0; k < NUM_THREADS; k++) begin
      if (pend[k] && segIdx[k] == minSeg) begin
        segClr[k] = 1'b1;
        qMask     = qMask | qtrHot[k];
      end
    end
  end

  logic                   hiHalf;
  logic [1:0]             halfQ;
  logic                   oneHalf;
  logic [NUM_THREADS-1:0] clrMask;

  assign hiHalf  = (qMask[1:0] == 2'b00);
  assign halfQ   = hiHalf ? qMask[3:2] : qMask[1:0];
  assign oneHalf = hiHalf || (qMask[3:2] == 2'b00);

  always_comb begin
    txnAddr = '0;
    txnSize = SZ_32;
    clrMask = '0;
    if (!modeQ) begin
      if (strictSingle) begin
        txnAddr = {wordIdx[0], {WORD_LSB{1'b0}}};
        txnSize = SZ_64;
        clrMask = '1;
      end else begin
        txnAddr = {addrQ[lowIdx][ADDR_W-1:QTR_LSB], {QTR_LSB{1'b0}}};
        txnSize = SZ_32;
        clrMask = NUM_THREADS'(1) << lowIdx;
      end
    end else begin
      clrMask = segClr;
      if (oneHalf && halfQ == 2'b11) begin
        txnAddr = {minSeg, hiHalf, {HALF_LSB{1'b0}}};
        txnSize = SZ_64;
      end else if (oneHalf) begin
        txnAddr = {minSeg, hiHalf, halfQ[1], {QTR_LSB{1'b0}}};
        txnSize = SZ_32;
      end else begin
        txnAddr = {minSeg, {SEG_LSB{1'b0}}};
        txnSize = SZ_128;
      end
    end
  end

  // checker state: alignment mask and last issued address
  logic [ADDR_W-1:0] sizeLowMask;
  logic [ADDR_W-1:0] lastAddr;
  logic              haveLast;

  always_comb begin
    unique case (txnSize)
      SZ_32:   sizeLowMask = ADDR_W'(31);
      SZ_64:   sizeLowMask = ADDR_W'(63);
      default: sizeLowMask = ADDR_W'(127);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      haveLast <= 1'b0;
      lastAddr <= '0;
    end else if (strobe.load) begin
      haveLast <= 1'b0;
    end else if (strobe.advance) begin
      haveLast <= 1'b1;
      lastAddr <= txnAddr;
    end
  end

  // R3
  size_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pendEmpty |-> ((txnAddr & sizeLowMask) == '0));

  // R6
  relaxed_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.advance && haveLast && modeQ) |-> (txnAddr > lastAddr));

  // R8
  pend_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.advance |=> ($countones(pend) < $past($countones(pend))));

  // R2
  txn_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pendEmpty && !strobe.advance && !strobe.load) |=>
      ($stable(txnAddr) && $stable(txnSize)));
endmodule

// File: rtl/halfwarp_coalescer.sv
module halfwarp_coalescer
  import coal_pkg::*;
#(
  parameter int NUM_THREADS = 16,
  parameter int ADDR_W      = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic                          in_mode,
  input  logic [NUM_THREADS-1:0]        in_mask,
  input  logic [NUM_THREADS*ADDR_W-1:0] in_addr,
  output logic                          out_valid,
  input  logic                          out_ready,
  output logic [ADDR_W-1:0]             out_addr,
  output logic [1:0]                    out_size,
  output logic                          done
);
  coalStrobe_t strobe;
  logic        pendEmpty;
  txnSize_e    txnSize;

  coal_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .inValid  (in_valid),
    .outReady (out_ready),
    .pendEmpty(pendEmpty),
    .inReady  (in_ready),
    .outValid (out_valid),
    .done     (done),
    .strobe   (strobe)
  );

  coal_datapath #(
    .NUM_THREADS(NUM_THREADS),
    .ADDR_W     (ADDR_W)
  ) u_datapath (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .inAddr   (in_addr),
    .inMask   (in_mask),
    .inMode   (in_mode),
    .pendEmpty(pendEmpty),
    .txnAddr  (out_addr),
    .txnSize  (txnSize)
  );

  assign out_size = txnSize;
endmodule

// File: tb/halfwarp_coalescer_bench.sv
`timescale 1ns/1ps
module halfwarp_coalescer_bench;
  localparam int NT = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          inValid = 1'b0;
  logic          inReady;
  logic          inMode = 1'b0;
  logic [NT-1:0] inMask = '0;
  logic [NT*32-1:0] inAddr = '0;
  logic          outValid;
  logic          outReady = 1'b0;
  logic [31:0]   outAddr;
  logic [1:0]    outSize;
  logic          done;

  int checks = 0;
  int errors = 0;

  logic [31:0] reqAddr [NT];
  logic [NT-1:0] reqMask;
  int expA[$];
  int expS[$];

  always #2 clk = ~clk;

  halfwarp_coalescer u_halfwarp_coalescer (
    .clk(clk), .rst_n(rst_n), .in_valid(inValid), .in_ready(inReady),
    .in_mode(inMode), .in_mask(inMask), .in_addr(inAddr),
    .out_valid(outValid), .out_ready(outReady), .out_addr(outAddr),
    .out_size(outSize), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural expectation: list of (address, size code)
  task automatic buildExpected(input bit mode);
    bit merge;
    int segs[$];
    expA.delete();
    expS.delete();
    if (!mode) begin
      merge = (reqMask == '1) && ((reqAddr[0] >> 2) % 16 == 0);
      for (int k = 0; k < NT; k++)
        if ((reqAddr[k] >> 2) != (reqAddr[0] >> 2) + k) merge = 0;
      if (merge) begin
        expA.push_back(int'(reqAddr[0] & ~32'd3));
        expS.push_back(1);
      end else begin
        for (int k = 0; k < NT; k++)
          if (reqMask[k]) begin
            expA.push_back(int'(reqAddr[k] & ~32'd31));
            expS.push_back(0);
          end
      end
    end else begin
      for (int k = 0; k < NT; k++)
        if (reqMask[k]) segs.push_back(int'(reqAddr[k] >> 7));
      segs.sort();
      for (int i = 0; i < segs.size(); i++) begin
        int q;
        int base;
        if (i > 0 && segs[i] == segs[i-1]) continue;
        q = 0;
        for (int k = 0; k < NT; k++)
          if (reqMask[k] && int'(reqAddr[k] >> 7) == segs[i])
            q = q | (1 << ((reqAddr[k] >> 5) & 3));
        base = segs[i] * 128;
        case (q)
          1, 2, 4, 8: begin
            for (int b = 0; b < 4; b++)
              if (q == (1 << b)) expA.push_back(base + 32 * b);
            expS.push_back(0);
          end
          3:  begin expA.push_back(base);      expS.push_back(1); end
          12: begin expA.push_back(base + 64); expS.push_back(1); end
          default: begin expA.push_back(base); expS.push_back(2); end
        endcase
      end
    end
  endtask

  task automatic runReq(input bit mode, input bit stall, input string tag);
    logic [31:0] pAddr;
    logic [1:0]  pSize;
    bit          prevStall;
    bit          finished;
    buildExpected(mode);
    @(negedge clk);
    inValid  = 1'b1;
    inMode   = mode;
    inMask   = reqMask;
    outReady = 1'b0;
    for (int k = 0; k < NT; k++) inAddr[k*32 +: 32] = reqAddr[k];
    #1 chk(inReady === 1'b1, "R1", "idle ready before accept", inReady, 1);
    @(negedge clk);
    // R10: scramble inputs after acceptance
    inValid = 1'b0;
    inMode  = ~mode;
    inMask  = ~reqMask;
    inAddr  = {NT{32'hDEAD_BEE0}};
    prevStall = 0;
    finished  = 0;
    pAddr = '0;
    pSize = '0;
    for (int cyc = 0; cyc < 60 && !finished; cyc++) begin
      outReady = stall ? (cyc % 3 != 1) : 1'b1;
      #1;
      chk(inReady === 1'b0, "R1", "not ready while busy", inReady, 0);
      chk(done === (expA.size() == 0), "R9", {tag, " done timing"},
          done, expA.size() == 0);
      if (done) begin
        finished = 1;
      end else begin
        chk(outValid === 1'b1, tag, "valid while pending", outValid, 1);
        if (prevStall)
          chk(outAddr === pAddr && outSize === pSize, "R2",
              "hold under stall", {outAddr, 30'b0, outSize}, {pAddr, 30'b0, pSize});
        if (outValid && outReady && expA.size() > 0) begin
          chk(outAddr === expA[0][31:0], tag, "address (inputs held per R10)",
              outAddr, expA[0]);
          chk(outSize === expS[0][1:0], tag, "size code R3", outSize, expS[0]);
          chk((outAddr & ((32'd32 << outSize) - 1)) == 0, "R3", "alignment",
              outAddr, 0);
          void'(expA.pop_front());
          void'(expS.pop_front());
        end
        prevStall = outValid && !outReady;
        pAddr = outAddr;
        pSize = outSize;
        @(negedge clk);
      end
    end
    chk(finished, "R9", {tag, " completion seen"}, finished, 1);
    @(negedge clk);
    outReady = 1'b0;
    #1 chk(inReady === 1'b1, "R9", "ready after done", inReady, 1);
  endtask

  task automatic fillLine(input int base, input int offWords);
    for (int k = 0; k < NT; k++) reqAddr[k] = 32'(base + 4 * (offWords + k));
    reqMask = '1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired R9 actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(inReady === 1'b0 || inReady === 1'b1, "R1", "reset in_ready known", inReady, 1);
    chk(outValid === 1'b0, "R1", "reset out_valid", outValid, 0);
    chk(done === 1'b0, "R9", "reset done", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    #1 chk(inReady === 1'b1, "R1", "idle after reset", inReady, 1);

    // offset sweep, even (segment-aligned) and odd (half-segment) bases
    for (int odd = 0; odd < 2; odd++) begin
      for (int off = 0; off <= 32; off++) begin
        fillLine(32'h2000 + 64 * odd, off);
        runReq(1'b1, off % 2 == 1, "R7");
        fillLine(32'h2000 + 64 * odd, off);
        runReq(1'b0, off % 3 == 0, ((odd * 16 + off) % 16 == 0) ? "R4" : "R5");
      end
    end

    // R6: segments presented in descending thread order
    for (int k = 0; k < NT; k++) reqAddr[k] = 32'h8000 + (15 - k) * 128 + 4 * k;
    reqMask = '1;
    runReq(1'b1, 1'b1, "R6");

    // R6: boundary crossing at word offset 8 -> two 32-byte pieces
    fillLine(32'h4000, 24);
    runReq(1'b1, 1'b0, "R6");

    // R8: one inactive thread breaks the strict merge
    fillLine(32'h3000, 0);
    reqMask[5] = 1'b0;
    reqAddr[5] = 32'hFFFF_FF00;
    runReq(1'b0, 1'b0, "R8");

    // R8: inactive far address must not add a segment
    fillLine(32'h3000, 0);
    reqMask = 16'h8001;
    reqAddr[7] = 32'h0010_0000;
    runReq(1'b1, 1'b1, "R8");

    // R8: empty masks in both modes
    fillLine(32'h5000, 3);
    reqMask = '0;
    runReq(1'b1, 1'b0, "R8");
    runReq(1'b0, 1'b0, "R8");

    // R7: single upper quarter, and all threads on one word
    for (int k = 0; k < NT; k++) reqAddr[k] = 32'h6000 + 32'd100;
    reqMask = '1;
    runReq(1'b1, 1'b0, "R7");
    runReq(1'b0, 1'b1, "R5");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule